// File: doc/BRIEF.md
# Post-Update Load/Store Execution Unit

This unit carries out integer loads and stores whose addressing uses the base register as it stands. Memory is accessed at the unmodified base value. The base plus an offset is then written back into the base register. The offset is either a signed immediate or a second register. The unit receives one already-decoded operation at a time, with these inputs:

- the access size;
- whether a narrow load is sign-extended;
- load or store;
- immediate or indexed offset;
- the three operand values;
- the 16-bit immediate field;
- the base and target register numbers.

The unit issues a single request on a 64-bit little-endian memory port, with valid/ready handshaking, and waits for the response. It then drives up to two register-file write ports in the same cycle. One is the loaded value to the target register. The other is the advanced pointer to the base register. Stores drive only the base write port, and only after memory has acknowledged the write.

A load whose base register number is zero, or equals its target register number, is rejected with an illegal-form pulse. An access whose address is not a multiple of its size is rejected with a misalignment pulse. Neither case touches memory or registers. No flag or status register is altered by any operation.

Top module: `pu_lsu`

## Requirements
- R1: A legal, aligned operation issues exactly one memory request, and its address equals the base operand value as presented when the operation was accepted, with no offset applied.
- R2: The base writeback value is base plus the sign-extended 16-bit immediate in immediate form, and base plus the index operand in indexed form.
- R3: For a doubleword access in immediate form, the offset is immediate bits 15..2 followed by two zero bits, sign-extended to 64 bits. Immediate bits 1..0 are ignored.
- R4: Load size codes are 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. Loads place the data in the low 8/16/32/64 bits of the target. Without the signed input, all higher bits are zero. With the signed input, halfword and word loads sign-extend to 64 bits. The signed input has no effect on byte and doubleword loads.
- R5: A store of 2^size bytes carries the low 2^size bytes of the store operand. They are placed on byte lanes starting at lane addr[2:0], where lane k is data bits 8k+7..8k, and the byte enables are set for exactly those lanes.
- R6: A load whose base register number is 0, or equals its target register number, gives a one-cycle illegal-form pulse in the cycle after acceptance, with no memory request and no register write. Stores are not subject to this rule.
- R7: An access whose address is not a multiple of its size gives a one-cycle misalignment pulse in the cycle after acceptance, with no request and no register write. The illegal-form check takes priority, so the two flags never rise together.
- R8: For a load, the target and base write enables rise together, only in the cycle the memory response is valid. For a store, only the base write enable rises, in the response cycle.
- R9: While an operation is outstanding (from acceptance until its response), the operation ready output is low. A pending request holds its valid signal and address until it is accepted.
- R10: After synchronous reset, the unit is ready, no request is pending, and no write enable or flag is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle and able to take an operation |
| op_size | input | 2 | Access size code, 0..3 for 1, 2, 4 or 8 bytes |
| op_signed | input | 1 | Sign-extend halfword or word load |
| op_store | input | 1 | 1 for store, 0 for load |
| op_indexed | input | 1 | 1 for register offset, 0 for immediate offset |
| base_val | input | 64 | Base register operand |
| index_val | input | 64 | Index register operand |
| store_val | input | 64 | Store data operand |
| imm_field | input | 16 | Immediate field |
| base_num | input | 5 | Base register number |
| tgt_num | input | 5 | Target register number |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_we | output | 1 | 1 for write |
| mem_req_size | output | 2 | Access size code |
| mem_req_be | output | 8 | Byte-lane enables |
| mem_req_wdata | output | 64 | Lane-placed write data |
| mem_rsp_valid | input | 1 | Response valid (read data or write acknowledge) |
| mem_rsp_rdata | input | 64 | Read data, aligned doubleword |
| tgt_we | output | 1 | Target register write enable |
| tgt_waddr | output | 5 | Target register number |
| tgt_wdata | output | 64 | Loaded value |
| base_we | output | 1 | Base register write enable |
| base_waddr | output | 5 | Base register number |
| base_wdata | output | 64 | Base plus offset |
| illegal_form | output | 1 | Rejected invalid load form |
| misaligned | output | 1 | Rejected misaligned access |

## Verification
Flags and the request valid are registered, so both appear in the first cycle after the clock edge that accepts an operation. The request then stays up through any number of not-ready cycles. Writebacks are combinational from the response, so they are due in exactly the cycle in which the memory model raises the response valid. The bench applies stimulus on the falling edge and samples 3 ns later, just before the next rising edge. Each accepted operation pushes its due events (request, then writeback, or a single flag) into a queue. A monitor pops them in order the moment the design shows each event, so an early, late, extra or missing event is reported as a mismatch. Memory stall and response latency are varied between operations, so the timing of each event is checked against the handshake and not against a fixed count.

// File: rtl/pu_lsu_pkg.sv
package pu_lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lsu_state_e;

endpackage

// File: rtl/pu_lsu_agu.sv
// Address side: pointer update, alignment test, byte enables, store lane placement.
module pu_lsu_agu
  import pu_lsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  acc_size_e              size_i,
  input  logic                   indexed_i,
  input  logic [XLEN-1:0]        base_i,
  input  logic [XLEN-1:0]        index_i,
  input  logic [XLEN-1:0]        store_i,
  input  logic [IMM_W-1:0]       imm_i,
  output logic [XLEN-1:0]        next_base_o,
  output logic [XLEN-1:0]        wdata_o,
  output logic [XLEN/8-1:0]      be_o,
  output logic                   misaligned_o
);
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int EXT_W  = XLEN - IMM_W;

  logic [XLEN-1:0]   d_off;
  logic [XLEN-1:0]   ds_off;
  logic [XLEN-1:0]   offset;
  logic [LANE_W-1:0] lane;
  logic [LANE_W:0]   lane_x;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W-1:0] size_mask;
  logic [XLEN-1:0]   trimmed;

  // immediate offsets: plain signed field, or word-scaled field with low bits forced to zero
  assign d_off  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign ds_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i[IMM_W-1:2], 2'b00};

  always_comb begin
    if (indexed_i)             offset = index_i;
    else if (size_i == SZ_DBL) offset = ds_off;
    else                       offset = d_off;
  end

  assign next_base_o = base_i + offset;

  assign lane      = base_i[LANE_W-1:0];
  assign lane_x    = {1'b0, lane};
  assign nbytes    = (LANE_W+1)'(1) << size_i;
  assign size_mask = nbytes[LANE_W-1:0] - LANE_W'(1);
  assign misaligned_o = |(lane & size_mask);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i] = ((LANE_W+1)'(i) >= lane_x) && ((LANE_W+1)'(i) < lane_x + nbytes);
    assign trimmed[8*i +: 8] = ((LANE_W+1)'(i) < nbytes) ? store_i[8*i +: 8] : 8'h00;
  end

  assign wdata_o = trimmed << {lane, 3'b000};

endmodule

// File: rtl/pu_lsu_ldfmt.sv
// Load side: select the addressed lanes and extend to full register width.
module pu_lsu_ldfmt
  import pu_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]            rdata_i,
  input  logic [$clog2(XLEN/8)-1:0]  lane_i,
  input  acc_size_e                  size_i,
  input  logic                       signed_i,
  output logic [XLEN-1:0]            result_o
);
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [XLEN-1:0] shifted;
  logic [LANE_W:0] nbytes;
  logic            msb;
  logic            extend;
  logic [7:0]      fill;

  assign shifted = rdata_i >> {lane_i, 3'b000};
  assign nbytes  = (LANE_W+1)'(1) << size_i;

  always_comb begin
    case (size_i)
      SZ_BYTE: msb = shifted[7];
      SZ_HALF: msb = shifted[15];
      SZ_WORD: msb = shifted[31];
      default: msb = shifted[XLEN-1];
    endcase
  end

  // only halfword and word have a signed flavour
  assign extend = signed_i && ((size_i == SZ_HALF) || (size_i == SZ_WORD));
  assign fill   = extend ? {8{msb}} : 8'h00;

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    assign result_o[8*j +: 8] = ((LANE_W+1)'(j) < nbytes) ? shifted[8*j +: 8] : fill;
  end

endmodule

// File: rtl/pu_lsu.sv
module pu_lsu
  import pu_lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 16,
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_size,
  input  logic                 op_signed,
  input  logic                 op_store,
  input  logic                 op_indexed,
  input  logic [XLEN-1:0]      base_val,
  input  logic [XLEN-1:0]      index_val,
  input  logic [XLEN-1:0]      store_val,
  input  logic [IMM_W-1:0]     imm_field,
  input  logic [REG_AW-1:0]    base_num,
  input  logic [REG_AW-1:0]    tgt_num,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [XLEN-1:0]      mem_req_addr,
  output logic                 mem_req_we,
  output logic [1:0]           mem_req_size,
  output logic [XLEN/8-1:0]    mem_req_be,
  output logic [XLEN-1:0]      mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [XLEN-1:0]      mem_rsp_rdata,
  output logic                 tgt_we,
  output logic [REG_AW-1:0]    tgt_waddr,
  output logic [XLEN-1:0]      tgt_wdata,
  output logic                 base_we,
  output logic [REG_AW-1:0]    base_waddr,
  output logic [XLEN-1:0]      base_wdata,
  output logic                 illegal_form,
  output logic                 misaligned
);
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);

  lsu_state_e        state_q;
  acc_size_e         size_in;
  acc_size_e         size_q;
  logic              accept;
  logic              form_bad;
  logic              agu_misaligned;
  logic [XLEN-1:0]   agu_next_base;
  logic [XLEN-1:0]   agu_wdata;
  logic [LANES-1:0]  agu_be;
  logic [XLEN-1:0]   next_base_q;
  logic [REG_AW-1:0] base_num_q;
  logic [REG_AW-1:0] tgt_num_q;
  logic              signed_q;
  logic              store_q;
  logic [LANE_W-1:0] lane_q;
  logic [XLEN-1:0]   addr_q;
  logic [LANES-1:0]  be_q;
  logic [XLEN-1:0]   wdata_q;
  logic              resp_done;

  assign size_in  = acc_size_e'(op_size);
  assign op_ready = (state_q == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign form_bad = !op_store && ((base_num == '0) || (base_num == tgt_num));

  pu_lsu_agu #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W)
  ) u_agu (
    .size_i       (size_in),
    .indexed_i    (op_indexed),
    .base_i       (base_val),
    .index_i      (index_val),
    .store_i      (store_val),
    .imm_i        (imm_field),
    .next_base_o  (agu_next_base),
    .wdata_o      (agu_wdata),
    .be_o         (agu_be),
    .misaligned_o (agu_misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      illegal_form <= 1'b0;
      misaligned   <= 1'b0;
      size_q       <= SZ_BYTE;
      next_base_q  <= '0;
      base_num_q   <= '0;
      tgt_num_q    <= '0;
      signed_q     <= 1'b0;
      store_q      <= 1'b0;
      lane_q       <= '0;
      addr_q       <= '0;
      be_q         <= '0;
      wdata_q      <= '0;
    end else begin
      illegal_form <= 1'b0;
      misaligned   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (form_bad) begin
              illegal_form <= 1'b1;
            end else if (agu_misaligned) begin
              misaligned <= 1'b1;
            end else begin
              state_q     <= ST_REQ;
              addr_q      <= base_val;
              size_q      <= size_in;
              store_q     <= op_store;
              be_q        <= agu_be;
              wdata_q     <= op_store ? agu_wdata : '0;
              next_base_q <= agu_next_base;
              base_num_q  <= base_num;
              tgt_num_q   <= tgt_num;
              signed_q    <= op_signed;
              lane_q      <= base_val[LANE_W-1:0];
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_we    = store_q;
  assign mem_req_size  = size_q;
  assign mem_req_be    = be_q;
  assign mem_req_wdata = wdata_q;

  assign resp_done = (state_q == ST_WAIT) && mem_rsp_valid;

  pu_lsu_ldfmt #(
    .XLEN (XLEN)
  ) u_ldfmt (
    .rdata_i  (mem_rsp_rdata),
    .lane_i   (lane_q),
    .size_i   (size_q),
    .signed_i (signed_q),
    .result_o (tgt_wdata)
  );

  assign tgt_we     = resp_done && !store_q;
  assign tgt_waddr  = tgt_num_q;
  assign base_we    = resp_done;
  assign base_waddr = base_num_q;
  assign base_wdata = next_base_q;

endmodule

// File: rtl/pu_lsu_chk.sv
module pu_lsu_chk #(
  parameter int XLEN   = 64,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_ready,
  input logic [XLEN-1:0]   base_val,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic [XLEN/8-1:0] mem_req_be,
  input logic              mem_rsp_valid,
  input logic              tgt_we,
  input logic [REG_AW-1:0] tgt_waddr,
  input logic              base_we,
  input logic [REG_AW-1:0] base_waddr,
  input logic              illegal_form,
  input logic              misaligned
);
  logic [XLEN-1:0] seen_base;

  always_ff @(posedge clk) begin
    if (rst) seen_base <= '0;
    else if (op_valid && op_ready) seen_base <= base_val;
  end

  assert_addr_is_old_base_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr == seen_base);

  assert_be_count_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> $countones(mem_req_be) == (1 << mem_req_size));

  assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    illegal_form |-> !mem_req_valid && !tgt_we && !base_we);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(illegal_form && misaligned));

  assert_misaligned_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> !mem_req_valid && !tgt_we && !base_we);

  assert_wb_on_response_R8: assert property (@(posedge clk) disable iff (rst)
    (tgt_we || base_we) |-> mem_rsp_valid);

  assert_wb_pair_R8: assert property (@(posedge clk) disable iff (rst)
    tgt_we |-> base_we && (tgt_waddr != base_waddr) && (base_waddr != '0));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !op_ready);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

endmodule

bind pu_lsu pu_lsu_chk #(
  .XLEN   (XLEN),
  .REG_AW (REG_AW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .base_val      (base_val),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_be    (mem_req_be),
  .mem_rsp_valid (mem_rsp_valid),
  .tgt_we        (tgt_we),
  .tgt_waddr     (tgt_waddr),
  .base_we       (base_we),
  .base_waddr    (base_waddr),
  .illegal_form  (illegal_form),
  .misaligned    (misaligned)
);

// File: tb/tb_pu_lsu.sv
`timescale 1ns/1ps
module tb_pu_lsu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic        op_store = 1'b0;
  logic        op_indexed = 1'b0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [63:0] store_val = '0;
  logic [15:0] imm_field = '0;
  logic [4:0]  base_num = '0;
  logic [4:0]  tgt_num = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_req_we;
  logic [1:0]  mem_req_size;
  logic [7:0]  mem_req_be;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        tgt_we;
  logic [4:0]  tgt_waddr;
  logic [63:0] tgt_wdata;
  logic        base_we;
  logic [4:0]  base_waddr;
  logic [63:0] base_wdata;
  logic        illegal_form;
  logic        misaligned;

  always #4 clk = ~clk;  // 125 MHz

  pu_lsu dut (.*);

  typedef struct {
    int          kind;   // 0 request, 1 writeback, 2 illegal, 3 misaligned
    logic [63:0] addr;
    logic        we;
    logic [1:0]  size;
    logic [7:0]  be;
    logic [63:0] wdata;
    logic        twe;
    logic [4:0]  tnum;
    logic [63:0] tval;
    logic [4:0]  bnum;
    logic [63:0] bval;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] mem [0:63];
  int          stall_cfg = 0;
  int          lat_cfg = 0;
  int          stall_left = 0;
  int          lat_left = 0;
  bit          pend = 0;
  logic [63:0] hold = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model
  always @(negedge clk) begin
    if (rst) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat_left == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = hold;
          pend = 0;
        end else lat_left--;
      end
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          mem_req_ready = 1'b0;
          stall_left--;
        end else mem_req_ready = 1'b1;
      end else begin
        mem_req_ready = 1'b0;
        stall_left = stall_cfg;
      end
      if (mem_req_valid && mem_req_ready) begin
        hold = mem[mem_req_addr[8:3]];
        if (mem_req_we)
          for (int k = 0; k < 8; k++)
            if (mem_req_be[k]) mem[mem_req_addr[8:3]][8*k +: 8] = mem_req_wdata[8*k +: 8];
        pend = 1;
        lat_left = lat_cfg;
      end
    end
  end

  // scoreboard monitor
  task automatic take(input int kind, output item_t it, output bit ok);
    ok = 0;
    if (exp_q.size() == 0) begin
      chk(0, "R9", "unexpected event kind", 64'(kind), 64'hFFFF);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind, it.tag, "event kind", 64'(kind), 64'(it.kind));
      ok = (it.kind == kind);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    bit ok;
    #3;
    if (!rst) begin
      if (mem_req_valid && mem_req_ready) begin
        take(0, it, ok);
        if (ok) begin
          chk(mem_req_addr == it.addr, it.tag, "req addr (R1)", mem_req_addr, it.addr);
          chk(mem_req_we == it.we, it.tag, "req we", 64'(mem_req_we), 64'(it.we));
          chk(mem_req_size == it.size, it.tag, "req size", 64'(mem_req_size), 64'(it.size));
          chk(mem_req_be == it.be, it.tag, "req be (R5)", 64'(mem_req_be), 64'(it.be));
          if (it.we) chk(mem_req_wdata == it.wdata, it.tag, "req wdata (R5)", mem_req_wdata, it.wdata);
        end
      end
      if (tgt_we || base_we) begin
        take(1, it, ok);
        if (ok) begin
          chk(tgt_we == it.twe, it.tag, "tgt_we (R8)", 64'(tgt_we), 64'(it.twe));
          chk(base_we, it.tag, "base_we (R8)", 64'(base_we), 64'd1);
          chk(base_waddr == it.bnum, it.tag, "base waddr", 64'(base_waddr), 64'(it.bnum));
          chk(base_wdata == it.bval, it.tag, "base wdata (R2)", base_wdata, it.bval);
          if (it.twe) begin
            chk(tgt_waddr == it.tnum, it.tag, "tgt waddr", 64'(tgt_waddr), 64'(it.tnum));
            chk(tgt_wdata == it.tval, it.tag, "tgt wdata (R4)", tgt_wdata, it.tval);
          end
        end
      end
      if (illegal_form) take(2, it, ok);
      if (misaligned)   take(3, it, ok);
    end
  end

  // driver: computes expectations from the requirements, queues them, issues the op
  task automatic run_op(input logic [1:0] sz, input logic sg, input logic st, input logic ix,
                        input logic [63:0] ra, input logic [63:0] rb, input logic [63:0] rs,
                        input logic [15:0] imm, input logic [4:0] ran, input logic [4:0] rtn,
                        input string tag);
    item_t       it;
    int          nb;
    int          lane;
    logic [63:0] mask;
    logic [63:0] off;
    logic [63:0] raw;
    bit          bad;
    nb   = 1 << sz;
    lane = int'(ra[2:0]);
    mask = (nb == 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
    if (ix) off = rb;
    else if (sz == 2'd3) off = {{48{imm[15]}}, imm[15:2], 2'b00};
    else off = {{48{imm[15]}}, imm};
    bad = !st && (ran == 5'd0 || ran == rtn);
    it = '{kind: 0, addr: ra, we: st, size: sz, be: 8'(((1 << nb) - 1) << lane),
           wdata: (rs & mask) << (8*lane), twe: 0, tnum: rtn, tval: '0,
           bnum: ran, bval: ra + off, tag: tag};
    if (bad) begin
      it.kind = 2; exp_q.push_back(it);
    end else if ((ra & 64'(nb - 1)) != 0) begin
      it.kind = 3; exp_q.push_back(it);
    end else begin
      exp_q.push_back(it);
      raw = (mem[ra[8:3]] >> (8*lane)) & mask;
      if (sg && (sz == 2'd1 || sz == 2'd2) && raw[8*nb-1]) raw = raw | ~mask;
      it.kind = 1; it.twe = !st; it.tval = raw;
      exp_q.push_back(it);
    end
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_size = sz; op_signed = sg; op_store = st; op_indexed = ix;
    base_val = ra; index_val = rb; store_val = rs; imm_field = imm;
    base_num = ran; tgt_num = rtn; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (!bad && (ra & 64'(nb - 1)) == 0)
      chk(!op_ready, "R9", "op_ready while outstanding", 64'(op_ready), 64'd0);
    while (exp_q.size() != 0 || !op_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R9 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'h0706050403020100 + {8{8'(i * 8)}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #3;
    chk(op_ready, "R10", "op_ready after reset", 64'(op_ready), 64'd1);
    chk(!mem_req_valid && !tgt_we && !base_we, "R10", "idle outputs after reset",
        {61'd0, mem_req_valid, tgt_we, base_we}, 64'd0);
    chk(!illegal_form && !misaligned, "R10", "flags after reset",
        {62'd0, illegal_form, misaligned}, 64'd0);

    // R5 R2: doubleword indexed store
    run_op(2'd3, 0, 1, 1, 64'h40, 64'h8, 64'hF0E1D2C3B4A59687, 16'h0, 5'd3, 5'd0, "R5_std_idx");
    // R4: byte loads, signed input has no effect on bytes; negative immediate (R2)
    run_op(2'd0, 0, 0, 0, 64'h47, 64'h0, 64'h0, 16'hFFF9, 5'd4, 5'd5, "R4_lbz_R2");
    run_op(2'd0, 1, 0, 0, 64'h47, 64'h0, 64'h0, 16'h0010, 5'd4, 5'd5, "R4_byte_signed_ignored");
    // R4: halfword and word, zero and signed
    run_op(2'd1, 0, 0, 1, 64'h46, 64'h100, 64'h0, 16'h0, 5'd6, 5'd7, "R4_lhz");
    run_op(2'd1, 1, 0, 1, 64'h46, 64'hFFFFFFFFFFFFFFFE, 64'h0, 16'h0, 5'd6, 5'd7, "R4_lha");
    run_op(2'd2, 0, 0, 0, 64'h44, 64'h0, 64'h0, 16'h0004, 5'd8, 5'd9, "R4_lwz");
    run_op(2'd2, 1, 0, 0, 64'h44, 64'h0, 64'h0, 16'h7FFC, 5'd8, 5'd9, "R4_lwa");
    run_op(2'd1, 1, 0, 0, 64'h40, 64'h0, 64'h0, 16'h0002, 5'd8, 5'd9, "R4_lha_positive");
    // R3: doubleword immediate, low immediate bits ignored, negative and positive
    run_op(2'd3, 1, 0, 0, 64'h40, 64'h0, 64'h0, 16'hFFF3, 5'd10, 5'd11, "R3_ld_neg");
    run_op(2'd3, 0, 0, 0, 64'h40, 64'h0, 64'h0, 16'h0106, 5'd10, 5'd11, "R3_ld_pos");
    // R5: narrow stores on various lanes, base register 0 is legal for stores (R6)
    stall_cfg = 3; lat_cfg = 4;
    run_op(2'd0, 0, 1, 0, 64'h43, 64'h0, 64'h11223344556677AB, 16'h0001, 5'd0, 5'd0, "R6_store_base0_R5");
    run_op(2'd1, 0, 1, 0, 64'h62, 64'h0, 64'hAAAABBBBCCCC1234, 16'hFFFE, 5'd12, 5'd0, "R5_sth");
    run_op(2'd2, 0, 1, 1, 64'h64, 64'h20, 64'h99998888DEADBEEF, 16'h0, 5'd12, 5'd0, "R5_stw");
    stall_cfg = 1; lat_cfg = 2;
    run_op(2'd2, 0, 0, 0, 64'h40, 64'h0, 64'h0, 16'h0, 5'd13, 5'd14, "R5_readback_byte");
    run_op(2'd3, 0, 0, 0, 64'h60, 64'h0, 64'h0, 16'h0, 5'd13, 5'd14, "R5_readback_sth_stw");
    stall_cfg = 0; lat_cfg = 0;
    // R6: invalid load forms
    run_op(2'd3, 0, 0, 0, 64'h40, 64'h0, 64'h0, 16'h0, 5'd0, 5'd2, "R6_base_zero");
    run_op(2'd2, 0, 0, 1, 64'h40, 64'h4, 64'h0, 16'h0, 5'd7, 5'd7, "R6_base_eq_tgt");
    // R7: misaligned, and illegal wins over misaligned
    run_op(2'd1, 0, 0, 0, 64'h41, 64'h0, 64'h0, 16'h0, 5'd3, 5'd4, "R7_lh_odd");
    run_op(2'd2, 0, 1, 0, 64'h42, 64'h0, 64'h55, 16'h0, 5'd3, 5'd0, "R7_stw_half_aligned");
    run_op(2'd3, 0, 0, 0, 64'h44, 64'h0, 64'h0, 16'h0, 5'd0, 5'd4, "R7_illegal_priority");
    // memory unchanged by the rejected store (R7): read back
    run_op(2'd3, 0, 0, 0, 64'h40, 64'h0, 64'h0, 16'h0, 5'd3, 5'd4, "R7_no_write");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "queue drained", 64'(exp_q.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule